// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is one general-purpose I/O port. Each bit of every register belongs to one pin. Software reaches the port through a simple word-addressed register bus with a single-cycle write strobe and a combinational read. Through that bus it sets the value each pin drives and decides which pins drive at all. It reads back the pin levels after they have been synchronized to the clock. It can also arm any pin as an interrupt source.

Each pin is armed in one of four trigger modes, chosen by two configuration bits: falling edge, low level, rising edge or high level. A trigger event on a pin whose routing bit is set latches that pin's status bit. The port has a single interrupt output. It is high while any latched status bit is also enabled.

Every writable register has three ways to be written: a plain write, a set alias and a clear alias. The set and clear aliases change only the bits written as 1, so software can update one pin without a read-modify-write. The status register ignores plain writes and the set alias, so it can be cleared only through its clear alias.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are zero and `irq_o` is low.
- R2: A bus word address is split as follows. `bus_word[4:2]` selects the register: 0 drive value, 1 pin level (read only), 2 drive enable, 3 interrupt routing, 4 interrupt enable, 5 trigger kind (0 edge, 1 level), 6 trigger polarity (0 falling/low, 1 rising/high), 7 status. `bus_word[1:0]` selects the operation: 0 plain write, 1 set alias, 2 clear alias, 3 no effect. A read at any operation code returns the selected register's current value, and this includes the polarity register.
- R3: A write through the set alias turns on the bits that are 1 in the write data. A write through the clear alias turns off the bits that are 1 in the write data. In both cases all other bits keep their value.
- R4: For each pin, the pad value is the drive value bit when the drive enable bit is 1, and `pad_in` otherwise. The pin level register returns the pad value after a two-flop synchronizer, and writes to it have no effect. `pad_out` and `pad_oe` present the drive value and drive enable registers.
- R5: The trigger code of a pin is {polarity, kind}. Code 0 latches status on a falling edge, 1 while the level is low, 2 on a rising edge and 3 while the level is high. An edge is a difference between the synchronized level and its value one cycle earlier.
- R6: A status bit latches only when its routing bit is 1. A pad change driven between clock edges shows in the status register after the third following rising edge and not before.
- R7: In level mode a status bit latches again on every cycle in which the active level is present, including the cycle in which it is cleared.
- R8: A status bit stays set until a 1 is written to its position through the status clear alias. Plain writes and set-alias writes to the status register have no effect.
- R9: `irq_o` is high exactly when the bitwise AND of status and interrupt enable is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_word | input | 5 | Word address: register index and alias operation |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Read data of the addressed register |
| pad_in | input | NPIN | External pin levels |
| pad_out | output | NPIN | Drive value towards the pads |
| pad_oe | output | NPIN | Per-pin drive enable |
| irq_o | output | 1 | Port interrupt |

## Verification
The bench builds the port with NPIN = 8. At that width the sweep can cover every pin in every one of the four trigger codes. Each pin is tested starting both low and high, while the other pins hold a fixed mixed pattern, and every expected status word is computed from the trigger rule. The small width also lets whole-register alias sequences, the loopback of driven pins and the three-edge latency be checked with exact values.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned WORD_W = IDX_W + 2;
  localparam int unsigned NREG   = 1 << IDX_W;

  localparam int unsigned REG_DOUT  = 0;
  localparam int unsigned REG_DIN   = 1;
  localparam int unsigned REG_OE    = 2;
  localparam int unsigned REG_ROUTE = 3;
  localparam int unsigned REG_EN    = 4;
  localparam int unsigned REG_LVL   = 5;
  localparam int unsigned REG_POL   = 6;
  localparam int unsigned REG_STAT  = 7;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NONE  = 2'd3
  } alias_op_e;
endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  alias_op_e    op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] apply_alias(input logic [W-1:0] cur,
                                               input logic [W-1:0] d,
                                               input alias_op_e o);
    case (o)
      OP_WRITE: return d;
      OP_SET:   return cur | d;
      OP_CLEAR: return cur & ~d;
      default:  return cur;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= apply_alias(q, wdata, op);
  end

  // R3
  set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));
  // R3
  clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_CLEAR) |=> ((q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] ff [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) ff[i] <= '0;
    end else begin
      ff[0] <= d;
      for (int i = 1; i < STAGES; i++) ff[i] <= ff[i-1];
    end
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] route,
  input  logic [W-1:0] kind_lvl,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  function automatic logic [W-1:0] detect(input logic [W-1:0] cur,
                                          input logic [W-1:0] old,
                                          input logic [W-1:0] lv,
                                          input logic [W-1:0] pl);
    logic [W-1:0] at_level, rise, fall, edge_hit;
    at_level = ~(cur ^ pl);
    rise     = cur & ~old;
    fall     = ~cur & old;
    edge_hit = (pl & rise) | (~pl & fall);
    return (lv & at_level) | (~lv & edge_hit);
  endfunction

  assign hit = route & detect(level, prev_q, kind_lvl, pol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat   <= '0;
    end else begin
      prev_q <= level;
      stat   <= (stat & ~clr_mask) | hit;
    end
  end

  // R6
  route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(route)) == '0));
  // R8
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~stat & $past(stat) & ~$past(clr_mask)) == '0));
  // R7
  level_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(route & kind_lvl & ~(level ^ pol)) & ~stat) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPIN        = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq_o
);
  logic [NPIN-1:0] regs [NREG];
  logic [IDX_W-1:0] idx;
  alias_op_e        op;
  logic [NPIN-1:0]  pad_val, din, stat, hit, clr_mask;

  assign idx = bus_word[WORD_W-1:2];
  assign op  = alias_op_e'(bus_word[1:0]);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == REG_DIN) begin : g_din
      assign regs[g] = din;
    end else if (g == REG_STAT) begin : g_stat
      assign regs[g] = stat;
    end else begin : g_rw
      gpio_alias_reg #(.W(NPIN)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr && idx == IDX_W'(g)),
        .op    (op),
        .wdata (bus_wdata),
        .q     (regs[g])
      );
    end
  end

  assign pad_out = regs[REG_DOUT];
  assign pad_oe  = regs[REG_OE];
  assign pad_val = (regs[REG_OE] & regs[REG_DOUT]) | (~regs[REG_OE] & pad_in);

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_val),
    .q     (din)
  );

  assign clr_mask = (bus_wr && idx == IDX_W'(REG_STAT) && op == OP_CLEAR)
                    ? bus_wdata : '0;

  gpio_trigger #(.W(NPIN)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (din),
    .route    (regs[REG_ROUTE]),
    .kind_lvl (regs[REG_LVL]),
    .pol      (regs[REG_POL]),
    .clr_mask (clr_mask),
    .stat     (stat),
    .hit      (hit)
  );

  assign irq_o     = |(stat & regs[REG_EN]);
  assign bus_rdata = regs[idx];

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |-> !irq_o);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (stat == '0 && pad_oe == '0));
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [4:0]   bus_word = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, pad_oe;
  logic         irq_o;

  int nchk = 0;
  int nerr = 0;

  gpio_irq_port #(.NPIN(W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_o(irq_o)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int idx, input int op, input logic [W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = 5'(idx * 4 + op); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int word, output logic [W-1:0] d);
    bus_word = 5'(word);
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [W-1:0] got, vin, lvl, pol, expv, ebit;
    settle(3);
    rst_n = 1'b1;
    settle(1);
    // R1 reset state
    for (int r = 0; r < 8; r++) begin
      rd(r * 4, got);
      check("R1 reg reset", got, 0);
    end
    check("R1 irq reset", irq_o, 0);
    check("R1 pad_oe reset", pad_oe, 0);

    // R5 R7 R9 sweep over every trigger code and pin
    for (int m = 0; m < 4; m++) begin
      lvl = m[0] ? 8'hFF : 8'h00;
      pol = m[1] ? 8'hFF : 8'h00;
      wr(5, 0, lvl); wr(6, 0, pol); wr(3, 0, 8'hFF); wr(4, 0, 8'hFF); wr(2, 0, 8'h00);
      for (int p = 0; p < W; p++) begin
        for (int s = 0; s < 2; s++) begin
          vin = 8'h3C; vin[p] = s[0];
          pad_in = vin;
          settle(4);
          wr(7, 2, 8'hFF);
          expv = lvl & ~(vin ^ pol);
          rd(28, got);
          check("R7 status after clear", got, expv);
          vin[p] = ~s[0];
          pad_in = vin;
          settle(4);
          ebit = (!m[0] && (m[1] == (s == 0))) ? (8'h01 << p) : 8'h00;
          expv = expv | (lvl & ~(vin ^ pol)) | ebit;
          rd(28, got);
          check("R5 status after toggle", got, expv);
          check("R9 irq after toggle", irq_o, |expv);
        end
      end
    end

    // R2 R3 alias operations on drive value and polarity
    wr(0, 0, 8'hA5); rd(0, got); check("R2 plain write", got, 8'hA5);
    wr(0, 1, 8'h0F); rd(0, got); check("R3 set alias", got, 8'hAF);
    wr(0, 2, 8'h81); rd(0, got); check("R3 clear alias", got, 8'h2E);
    wr(0, 3, 8'hFF); rd(0, got); check("R2 op3 no effect", got, 8'h2E);
    rd(1, got); check("R2 read at set alias", got, 8'h2E);
    wr(6, 0, 8'h5A); rd(24, got); check("R2 polarity readback", got, 8'h5A);
    wr(6, 2, 8'h02); rd(26, got); check("R3 polarity clear", got, 8'h58);

    // R4 loopback and read-only level register
    wr(0, 0, 8'h05); wr(2, 0, 8'h0F);
    pad_in = 8'hF0;
    settle(3);
    rd(4, got); check("R4 pad value", got, 8'hF5);
    check("R4 pad_out", pad_out, 8'h05);
    check("R4 pad_oe", pad_oe, 8'h0F);
    wr(1, 0, 8'h00); rd(4, got); check("R4 level write ignored", got, 8'hF5);

    // R6 routing gate and latency (rising edge mode)
    wr(2, 0, 8'h00); wr(5, 0, 8'h00); wr(6, 0, 8'hFF); wr(4, 0, 8'hFF); wr(3, 0, 8'h00);
    pad_in = 8'h00; settle(4); wr(7, 2, 8'hFF);
    pad_in = 8'hFF; settle(4);
    rd(28, got); check("R6 unrouted no status", got, 8'h00);
    check("R6 unrouted irq low", irq_o, 0);
    wr(3, 0, 8'h0F);
    pad_in = 8'h00; settle(4); wr(7, 2, 8'hFF);
    pad_in = 8'hFF; settle(2);
    rd(28, got); check("R6 before third edge", got, 8'h00);
    settle(1);
    rd(28, got); check("R6 at third edge", got, 8'h0F);

    // R8 status write protection
    wr(7, 0, 8'h00); rd(28, got); check("R8 plain write ignored", got, 8'h0F);
    wr(7, 1, 8'hFF); rd(28, got); check("R8 set alias ignored", got, 8'h0F);
    wr(7, 2, 8'h03); rd(28, got); check("R8 clear alias", got, 8'h0C);

    // R9 enable gating
    wr(4, 0, 8'h00); check("R9 irq disabled", irq_o, 0);
    wr(4, 0, 8'h04); check("R9 irq enabled bit", irq_o, 1);
    wr(4, 0, 8'h03); check("R9 irq other bits", irq_o, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule